// File: doc/BRIEF.md
# Pipelined Ternary Inner Product

This block computes the inner product of two short vectors whose elements are ternary, each one of −1, 0 or +1. Every element is carried as a two-bit code with one bit flagging a positive value and the other flagging a negative value. No multiplier is used. The product of two ternary elements is either zero or a sign, so the sum reduces to counting the lane pairs whose signs agree, counting the lane pairs whose signs differ, and subtracting the second count from the first.

The work is split over three registered stages. The first stage sets per-lane agreement and disagreement flags. The second stage adds those flags into two small counts. The third stage subtracts the counts and registers a signed result. A valid bit moves with the data through each stage. The pipeline accepts one operand pair on every clock, so a steady input stream gives a steady output stream three cycles later. A stage register is written only when the data arriving at it is valid. Between valid outputs, the output therefore keeps the last result it produced.

Top module: `tern_dot8_pipe`

## Requirements
- R1: Element i of each operand occupies bits [2i+1:2i]. Code 2'b01 is +1, code 2'b10 is −1, and code 2'b00 is 0. The illegal code 2'b11 is treated exactly like 0.
- R2: Each lane in which both elements are nonzero and have the same sign adds +1 to the result.
- R3: A lane in which either element is zero (or illegal) contributes nothing. An all-zero operand gives a result of 0.
- R4: Each lane in which both elements are nonzero and have opposite signs adds −1. The result is an 8-bit two's-complement value and always lies in −8..+8.
- R5: Latency is exactly three clocks. valid_out is high after the third rising edge that follows the edge at which valid_in was sampled high, and at no other time.
- R6: A new operand pair can be accepted on every clock. Consecutive valid inputs produce consecutive valid outputs in the same order.
- R7: While valid_out is low, result keeps the value of the most recent valid output (0 if there has been none since reset).
- R8: The active-low reset acts asynchronously. It clears every valid bit and drives result to 0 at once, without waiting for a clock edge.
- R9: The fixed results are as follows. All +1 against all +1 gives 8. All +1 against all −1 gives −8. Zero operands give 0. Six agreeing lanes and two opposing lanes give 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operand pair on vec_a/vec_b is valid this cycle |
| vec_a | input | 2*LANES (16) | First ternary operand, two bits per element |
| vec_b | input | 2*LANES (16) | Second ternary operand, two bits per element |
| valid_out | output | 1 | result carries a new inner product |
| result | output | RES_W (8) | Signed inner product, two's complement |

## Verification
The hardest situation to create from the ports is an asynchronous reset that arrives while all three stages hold valid data. The bench reaches it by streaming valid pairs without gaps, then pulling reset low between clock edges and checking the outputs before the next edge. It then checks that none of the data in flight appears after release. A second awkward case is an idle gap in which the operand inputs keep changing. The bench drives random operands with valid_in low during such gaps and checks that result does not move. Illegal element codes are mixed into the random traffic so that they meet every sign combination in the other operand.

// File: rtl/tern_dot_pkg.sv
package tern_dot_pkg;

    // Two-bit ternary element code: bit 0 flags +1, bit 1 flags -1.
    typedef enum logic [1:0] {
        TRIT_ZERO = 2'b00,
        TRIT_POS  = 2'b01,
        TRIT_NEG  = 2'b10,
        TRIT_BAD  = 2'b11
    } trit_e;

    function automatic logic trit_is_pos(input logic [1:0] code);
        return code == TRIT_POS;
    endfunction

    function automatic logic trit_is_neg(input logic [1:0] code);
        return code == TRIT_NEG;
    endfunction

endpackage

// File: rtl/tern_dot_decode.sv
module tern_dot_decode #(
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2*LANES-1:0] in_a,
    input  logic [2*LANES-1:0] in_b,
    output logic               out_valid,
    output logic [LANES-1:0]   out_agree,
    output logic [LANES-1:0]   out_oppose
);
    import tern_dot_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [LANES-1:0] agree;
        logic [LANES-1:0] oppose;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [LANES-1:0] lane_agree, lane_oppose;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic a_pos, a_neg, b_pos, b_neg;
        assign a_pos = trit_is_pos(in_a[2*g +: 2]);
        assign a_neg = trit_is_neg(in_a[2*g +: 2]);
        assign b_pos = trit_is_pos(in_b[2*g +: 2]);
        assign b_neg = trit_is_neg(in_b[2*g +: 2]);
        assign lane_agree[g]  = (a_pos & b_pos) | (a_neg & b_neg);
        assign lane_oppose[g] = (a_pos & b_neg) | (a_neg & b_pos);
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.agree  = lane_agree;
            st_d.oppose = lane_oppose;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_agree  = st_q.agree;
    assign out_oppose = st_q.oppose;

endmodule

// File: rtl/tern_dot_count.sv
module tern_dot_count #(
    parameter int LANES = 8,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LANES-1:0] in_agree,
    input  logic [LANES-1:0] in_oppose,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_pos,
    output logic [CNT_W-1:0] out_neg
);

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] neg;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] sum_pos, sum_neg;

    // Plain adder chains of one-bit terms; no multiply anywhere.
    always_comb begin
        sum_pos = '0;
        sum_neg = '0;
        for (int i = 0; i < LANES; i++) begin
            sum_pos = sum_pos + CNT_W'(in_agree[i]);
            sum_neg = sum_neg + CNT_W'(in_oppose[i]);
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.pos = sum_pos;
            st_d.neg = sum_neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_pos   = st_q.pos;
    assign out_neg   = st_q.neg;

endmodule

// File: rtl/tern_dot_sub.sv
module tern_dot_sub #(
    parameter int CNT_W = 4,
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] in_pos,
    input  logic [CNT_W-1:0] in_neg,
    output logic             out_valid,
    output logic [RES_W-1:0] out_res
);

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] res;
    } sub_st_t;

    sub_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            // Counts are non-negative; zero-extend then subtract modulo 2^RES_W.
            st_d.res = RES_W'(in_pos) - RES_W'(in_neg);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_res   = st_q.res;

endmodule

// File: rtl/tern_dot8_pipe.sv
module tern_dot8_pipe #(
    parameter int LANES = 8,
    parameter int RES_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [2*LANES-1:0] vec_a,
    input  logic [2*LANES-1:0] vec_b,
    output logic               valid_out,
    output logic [RES_W-1:0]   result
);
    // RES_W must be at least CNT_W + 1 to hold -LANES..+LANES.
    localparam int CNT_W = $clog2(LANES + 1);

    logic             s1_valid;
    logic [LANES-1:0] s1_agree, s1_oppose;
    logic             s2_valid;
    logic [CNT_W-1:0] s2_pos, s2_neg;

    tern_dot_decode #(.LANES(LANES)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (valid_in),
        .in_a       (vec_a),
        .in_b       (vec_b),
        .out_valid  (s1_valid),
        .out_agree  (s1_agree),
        .out_oppose (s1_oppose)
    );

    tern_dot_count #(.LANES(LANES), .CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s1_valid),
        .in_agree  (s1_agree),
        .in_oppose (s1_oppose),
        .out_valid (s2_valid),
        .out_pos   (s2_pos),
        .out_neg   (s2_neg)
    );

    tern_dot_sub #(.CNT_W(CNT_W), .RES_W(RES_W)) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s2_valid),
        .in_pos    (s2_pos),
        .in_neg    (s2_neg),
        .out_valid (valid_out),
        .out_res   (result)
    );

endmodule

// File: rtl/tern_dot8_pipe_chk.sv
module tern_dot8_pipe_chk #(
    parameter int LANES = 8,
    parameter int RES_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid_in,
    input logic [2*LANES-1:0] vec_a,
    input logic [2*LANES-1:0] vec_b,
    input logic               valid_out,
    input logic [RES_W-1:0]   result
);
    // Edges seen since reset release, saturating at 3.
    logic [1:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  since_rst_q <= 2'd0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    // R5: the output valid is the input valid three edges late
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) |-> (valid_out == $past(valid_in, 3)));

    // R3: a zero operand yields a zero result
    a_r3_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3 && valid_out &&
         $past(valid_in && (vec_a == '0 || vec_b == '0), 3)) |-> (result == '0));

    // R4: the result stays within -LANES..+LANES
    a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (int'($signed(result)) >= -LANES && int'($signed(result)) <= LANES));

    // R7: no valid output, no change of result
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> $stable(result));

    // R8: outputs are cleared while reset is low
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r8_reset_clear: assert (valid_out == 1'b0 && result == '0);
        end
    end

endmodule

bind tern_dot8_pipe tern_dot8_pipe_chk #(.LANES(LANES), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .vec_a     (vec_a),
    .vec_b     (vec_b),
    .valid_out (valid_out),
    .result    (result)
);

// File: tb/sim_tern_dot8_pipe.sv
`timescale 1ns/100ps
module sim_tern_dot8_pipe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [15:0] vec_a = '0;
    logic [15:0] vec_b = '0;
    logic        valid_out;
    logic [7:0]  result;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        bit    v;
        int    val;
        string tag;
    } ent_t;

    ent_t hist[$];
    int   held = 0;

    always #2.5 clk = ~clk;

    tern_dot8_pipe u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .vec_a     (vec_a),
        .vec_b     (vec_b),
        .valid_out (valid_out),
        .result    (result)
    );

    // Behavioural reference: element values are signed integers.
    function automatic int elem(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b10) return -1;
        return 0;
    endfunction

    function automatic int ref_dot(input logic [15:0] a, input logic [15:0] b);
        int s = 0;
        for (int i = 0; i < 8; i++) s += elem(a[2*i +: 2]) * elem(b[2*i +: 2]);
        return s;
    endfunction

    task automatic check(input string tag, input int act_v, input int exp_v,
                         input int act_r, input int exp_r);
        tests++;
        if (act_v != exp_v || act_r != exp_r) begin
            fails++;
            $display("FAIL %s: valid_out=%0d result=%0d, expected valid_out=%0d result=%0d",
                     tag, act_v, act_r, exp_v, exp_r);
        end
    endtask

    // One cycle: compare outputs against the entry driven three cycles ago, then drive.
    task automatic step(input bit v, input logic [15:0] a, input logic [15:0] b,
                        input string tag);
        ent_t e;
        int   ev;
        string t;
        @(negedge clk);
        ev = 0;
        t  = "R7";
        if (hist.size() >= 3) begin
            e = hist[hist.size() - 3];
            if (e.v) begin
                ev   = 1;
                held = e.val;
                t    = e.tag;
            end else begin
                t = "R5";
            end
        end
        check(t, int'(valid_out), ev, int'($signed(result)), held);
        valid_in = v;
        vec_a    = a;
        vec_b    = b;
        e.v   = v;
        e.val = ref_dot(a, b);
        e.tag = tag;
        hist.push_back(e);
        if (hist.size() > 4) void'(hist.pop_front());
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'($urandom), 16'($urandom), "R7");
    endtask

    task automatic mid_reset();
        @(negedge clk);
        #1;
        rst_n    = 1'b0;
        valid_in = 1'b0;
        #0.5;
        // R8: cleared without waiting for an edge
        check("R8", int'(valid_out), 0, int'($signed(result)), 0);
        repeat (2) @(negedge clk);
        check("R8", int'(valid_out), 0, int'($signed(result)), 0);
        rst_n = 1'b1;
        hist.delete();
        held = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: state during reset
        check("R8", int'(valid_out), 0, int'($signed(result)), 0);
        rst_n = 1'b1;

        // R9 canonical cases, back to back
        step(1'b1, 16'h5555, 16'h5555, "R9");
        step(1'b1, 16'h5555, 16'hAAAA, "R9");
        step(1'b1, 16'h0000, 16'h0000, "R9");
        step(1'b1, 16'h5555, 16'h555A, "R9");
        idle(4);

        // R2 same sign, R4 opposite sign, R3 zero lanes
        step(1'b1, 16'hAAAA, 16'hAAAA, "R2");
        step(1'b1, 16'hAAAA, 16'h5555, "R4");
        step(1'b1, 16'h5555, 16'h0000, "R3");
        step(1'b1, 16'h5A05, 16'h5A50, "R3");
        // R1 illegal code treated as zero, and the field positions
        step(1'b1, 16'hFFFF, 16'h5555, "R1");
        step(1'b1, 16'hFFFF, 16'hAAAA, "R1");
        step(1'b1, 16'h0003, 16'h0001, "R1");
        step(1'b1, 16'h4001, 16'h8001, "R1");
        step(1'b1, 16'h5557, 16'h5556, "R1");
        idle(5);

        // R5 single pulse with idles around it, R7 hold while inputs move
        step(1'b1, 16'h0159, 16'h0155, "R5");
        idle(6);

        // R6 unbroken stream of random pairs
        for (int i = 0; i < 60; i++) step(1'b1, 16'($urandom), 16'($urandom), "R6");
        // Mixed valid pattern
        for (int i = 0; i < 120; i++)
            step(1'($urandom), 16'($urandom), 16'($urandom), "R4");
        idle(4);

        // R8: reset while all stages hold valid data
        for (int i = 0; i < 5; i++) step(1'b1, 16'h5555, 16'h5555, "R6");
        mid_reset();
        idle(5);
        step(1'b1, 16'hAAAA, 16'h5559, "R8");
        idle(4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule